// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands one bit per clock. It holds an augend register and an addend register. Both shift right, so the least significant bits meet first. A single full adder combines the two low bits with a stored carry. Each sum bit is shifted into the top of the augend register, into the place left free as the augend moves out. After as many shift clocks as the register has bits, the augend register holds the sum and the carry flip-flop holds the carry-out.

The addend register rotates rather than drains, so it holds the same value after a pass. A user loads A and B, pulses `start`, and waits for `done`. To add a third operand, the user loads it into B and pulses `start` again. A is left alone, so the new pass adds the operand to the running sum. Each pass begins with a cleared carry. The carry out of the most recent pass stays visible on `cout` until the next pass completes.

Top module: `serial_accum`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `a_out` is 0, `busy` is 0, `done` is 0 and `cout` is 0. The B register is also cleared.
- R2: While `busy` is 0, a high `ld_a` makes `a_out` equal `a_in` after the next rising edge, and a high `ld_b` stores `b_in` in the same way. With no load and no pass running, `a_out` holds its value.
- R3: While `busy` is 1, `ld_a` and `ld_b` are ignored. `a_out` follows only the adding sequence, and the sums of later passes show that B was not changed.
- R4: A `start` seen while idle raises `busy` after that edge. `busy` stays high for exactly W = 4 cycles.
- R5: `done` is high for exactly one cycle, the cycle in which `busy` has just fallen. In that cycle `a_out` equals (A + B) mod 2^W.
- R6: `cout` equals bit W of A + B from the cycle `done` rises. It holds that value, through loads and the next pass, until the next pass completes.
- R7: The carry is cleared when a pass starts. The carry left by a previous pass never enters the next sum. For example, 1011 + 1001 gives `a_out` = 0100 with `cout` = 1, and adding 0001 after that gives 0101 with `cout` = 0.
- R8: A `start` while `busy` is 1 is ignored. The running pass neither restarts nor lengthens.
- R9: Bits are processed least significant first. After k shift clocks of a pass (1 ≤ k ≤ W), `a_out` equals the low k sum bits placed in the top k positions, above the original A shifted right by k.
- R10: B keeps its value across a pass. A second `start` with no reload adds the same B again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_a | input | 1 | Load `a_in` into the augend register when idle |
| a_in | input | W | Parallel value for the augend register |
| ld_b | input | 1 | Load `b_in` into the addend register when idle |
| b_in | input | W | Parallel value for the addend register |
| start | input | 1 | Begin an add pass when idle |
| a_out | output | W | Augend register contents; holds the sum after a pass |
| busy | output | 1 | High while a pass is shifting |
| done | output | 1 | One-cycle pulse when a pass has finished |
| cout | output | 1 | Carry out of the last completed pass |

## Verification
The edge that samples `start` is edge E0. `busy` rises after E0. Each of edges E1 to E4 shifts in one sum bit, so the partial value of `a_out` is due one edge after each shift clock. `done`, the final sum and `cout` are all due after E4, and `done` falls after E5. A load is due on `a_out` after the single edge that samples it. The bench drives its inputs on falling edges and samples just before it drives the next value. It compares each of these values, in its own cycle, against sums it computes from a model of A, B and the last carry. Random passes also toggle loads and `start` in the middle of a pass, and those per-cycle checks show that these inputs had no effect.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int DEF_WIDTH = 4;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_ADD  = 1'b1
  } phase_t;
endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         lsb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift) begin
      q <= {ser_in, q[W-1:1]};
    end else if (load) begin
      q <= load_val;
    end
  end

  assign lsb = q[0];

  // R2: a load taken while not shifting appears on the next edge
  p_load_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (load && !shift) |=> (q == $past(load_val)));

  // R9: a shift moves the register right by one position, with the serial bit entering at the top
  p_shift_right_r9: assert property (@(posedge clk) disable iff (rst)
    shift |=> (q[W-2:0] == $past(q[W-1:1])));
endmodule

// File: rtl/sa_bit_adder.sv
module sa_bit_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ cin;
    co = (x & y) | (cin & (x ^ y));
  end
endmodule

// File: rtl/sa_sequencer.sv
module sa_sequencer
  import sa_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done,
  output logic go,
  output logic last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;

  assign busy = (phase == PH_ADD);
  assign go   = start && (phase == PH_IDLE);
  assign last = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        phase <= PH_ADD;
        cnt   <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_CNT) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  // R4: a pass keeps running until its last count
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && (cnt != LAST_CNT)) |=> busy);

  // R4: a pass ends right after its last count, and done rises with it
  p_busy_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && (cnt == LAST_CNT)) |=> (!busy && done));

  // R5: done lasts a single cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: start during a pass does not reset the count
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && (cnt != LAST_CNT)) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/serial_accum.sv
module serial_accum #(
  parameter int W = sa_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_a,
  input  logic [W-1:0] a_in,
  input  logic         ld_b,
  input  logic [W-1:0] b_in,
  input  logic         start,
  output logic [W-1:0] a_out,
  output logic         busy,
  output logic         done,
  output logic         cout
);
  logic         go, last;
  logic         a_lsb, b_lsb;
  logic         sum_bit, carry_nxt;
  logic         carry_q;
  logic [W-1:0] b_q;
  logic         ld_a_ok, ld_b_ok;

  sa_sequencer #(.W(W)) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .go(go), .last(last)
  );

  assign ld_a_ok = ld_a && !busy;
  assign ld_b_ok = ld_b && !busy;

  sa_shift_reg #(.W(W)) reg_a_i (
    .clk(clk), .rst(rst), .load(ld_a_ok), .load_val(a_in),
    .shift(busy), .ser_in(sum_bit), .q(a_out), .lsb(a_lsb)
  );

  sa_shift_reg #(.W(W)) reg_b_i (
    .clk(clk), .rst(rst), .load(ld_b_ok), .load_val(b_in),
    .shift(busy), .ser_in(b_lsb), .q(b_q), .lsb(b_lsb)
  );

  sa_bit_adder fa_i (
    .x(a_lsb), .y(b_lsb), .cin(carry_q), .s(sum_bit), .co(carry_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || go) begin
      carry_q <= 1'b0;
    end else if (busy) begin
      carry_q <= carry_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cout <= 1'b0;
    end else if (last) begin
      cout <= carry_nxt;
    end
  end

  // R7: every pass starts with a cleared carry
  p_carry_clear_r7: assert property (@(posedge clk) disable iff (rst)
    go |=> (carry_q == 1'b0));

  // R2: with no pass and no load, A holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ld_a) |=> (a_out == $past(a_out)));

  // R3: a load request during a pass leaves B as a pure rotation
  p_b_rotates_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (b_q == {$past(b_q[0]), $past(b_q[W-1:1])}));

  // R6: cout changes only at the end of a pass
  p_cout_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(cout));
endmodule

// File: tb/serial_accum_tb_top.sv
`timescale 1ns/1ps
module serial_accum_tb_top;
  localparam int  W     = 4;
  localparam int  MASK  = (1 << W) - 1;
  localparam real CLK_P = 5.0;

  logic         clk = 1'b0;
  logic         rst, ld_a, ld_b, start;
  logic [W-1:0] a_in, b_in, a_out;
  logic         busy, done, cout;

  int checks = 0;
  int fails  = 0;
  int mA = 0, mB = 0, mC = 0;
  bit finished = 0;

  always #(CLK_P / 2) clk = ~clk;

  serial_accum #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .ld_a(ld_a), .a_in(a_in), .ld_b(ld_b), .b_in(b_in),
    .start(start), .a_out(a_out), .busy(busy), .done(done), .cout(cout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int partial(input int a0, input int b0, input int k);
    int s = a0 + b0;
    return (((s & ((1 << k) - 1)) << (W - k)) | (a0 >> k)) & MASK;
  endfunction

  task automatic load_a(input int v);
    @(negedge clk); ld_a = 1'b1; a_in = W'(v);
    @(negedge clk); ld_a = 1'b0;
    mA = v & MASK;
    chk(a_out == mA, "R2 load A", a_out, mA);
    chk(cout == mC, "R6 cout held over load", cout, mC);
  endtask

  task automatic load_b(input int v);
    @(negedge clk); ld_b = 1'b1; b_in = W'(v);
    @(negedge clk); ld_b = 1'b0;
    mB = v & MASK;
  endtask

  task automatic do_pass(input bit noise);
    int s;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R4 busy rises", busy, 1);
    chk(cout == mC, "R6 cout held during pass", cout, mC);
    s = mA + mB;
    for (int k = 1; k <= W; k++) begin
      if (noise) begin
        ld_a = 1'b1; a_in = W'($urandom);
        ld_b = 1'b1; b_in = W'($urandom);
        start = 1'($urandom);
      end
      @(negedge clk);
      ld_a = 1'b0; ld_b = 1'b0; start = 1'b0;
      chk(a_out == partial(mA, mB, k), "R9 R3 partial A", a_out, partial(mA, mB, k));
      if (k < W) begin
        chk(busy == 1'b1, "R4 R8 busy mid pass", busy, 1);
        chk(done == 1'b0, "R5 done early", done, 0);
      end
    end
    chk(busy == 1'b0, "R4 busy falls", busy, 0);
    chk(done == 1'b1, "R5 done rises", done, 1);
    chk(a_out == (s & MASK), "R5 sum", a_out, s & MASK);
    chk(cout == ((s >> W) & 1), "R6 cout", cout, (s >> W) & 1);
    mA = s & MASK;
    mC = (s >> W) & 1;
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", done, 0);
    chk(a_out == mA, "R2 idle hold", a_out, mA);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; ld_a = 0; ld_b = 0; start = 0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    chk(a_out == 0 && busy == 0 && done == 0 && cout == 0, "R1 reset in", a_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(a_out == 0 && busy == 0 && done == 0 && cout == 0, "R1 reset out", a_out, 0);
    // R1: B is cleared, so a pass with A = 3 returns 3
    load_a(3);
    do_pass(1'b0);
    chk(a_out == 3, "R1 B cleared", a_out, 3);

    // R7: directed accumulation with carry not leaking
    load_a(4'b1011);
    load_b(4'b1001);
    do_pass(1'b0);
    chk(a_out == 4'b0100 && cout == 1'b1, "R7 first pass", {cout, a_out}, 5'b10100);
    load_b(4'b0001);
    do_pass(1'b0);
    chk(a_out == 4'b0101 && cout == 1'b0, "R7 carry cleared", {cout, a_out}, 5'b00101);
    // R10: same B added again
    do_pass(1'b0);
    chk(a_out == 4'b0110, "R10 B retained", a_out, 6);

    // corner: all ones
    load_a(15); load_b(15);
    do_pass(1'b0);
    chk(a_out == 14 && cout == 1, "R6 max operands", {cout, a_out}, 30);
    load_a(0); load_b(0);
    do_pass(1'b0);
    chk(cout == 0, "R6 zero operands", cout, 0);

    // random passes with inputs toggled during a pass (R3, R8)
    for (int i = 0; i < 60; i++) begin
      if ($urandom % 2) load_a($urandom);
      if ($urandom % 3 != 0) load_b($urandom);
      do_pass(1'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule